// File: doc/BRIEF.md
# Fan-in Borrow Select Relay

This block sits beside one time-borrowing flip-flop in a pipeline that masks late data by sampling a second time after a short, discrete delay. It decides how long that delay is in the next cycle. Every upstream borrowing element in the fan-in cone reports two things: the select it is currently using and whether its early and late samples disagreed. An element that saw a mismatch asks the next stage to borrow one interval more than it did. An element that saw no mismatch asks for nothing. The block takes the largest of these requests across the whole fan-in and registers it as the local select.

The select has three legal codes. 00 is the silent borrowing interval. 01 and 10 are the two error-detection intervals. When the local element itself mismatches while its select is an error-detection code, the block raises a registered error flag for the central error controller. A mismatch under code 00 is masked and not reported. The block also presents the local element's own relay request, so chains of these blocks can be wired stage to stage.

Clearing the enable turns borrowing off. The element then behaves as a plain flip-flop: the select returns to 00, and neither the flag nor the relay request is raised.

Top module: `borrow_relay_sel`

## Requirements
- R1: While reset is asserted, `selOut` is 00 and `errFlag` is 0.
- R2: An upstream lane with its error bit set requests its own select plus one (00 becomes 01, 01 becomes 10). The lane's select sits at bits [2i+1:2i] of `upSel`.
- R3: An upstream lane with its error bit clear requests 00, whatever its select input.
- R4: `selOut` becomes the maximum of all lane requests, compared as unsigned 2-bit values.
- R5: A request saturates at 10. An erroring lane whose select is 10 or 11 requests 10, so the select never wraps to 00.
- R6: `selOut` changes only at a rising clock edge, one cycle after its inputs. With borrowing enabled and no upstream error, it is 00 after the next edge.
- R7: If `localMismatch` is high while `selOut` is 01 or 10 and borrowing is enabled, `errFlag` is 1 after the next edge.
- R8: If `localMismatch` is high while `selOut` is 00, `errFlag` is 0 after the next edge, and it is also 0 after any edge where `localMismatch` was low.
- R9: With `borrowEn` low, `selOut` and `errFlag` are 00 and 0 after the next edge, and `relayOut` is 00 at once, whatever the errors.
- R10: `relayOut` is the local request. With `borrowEn` and `localMismatch` high it equals `selOut` plus one, saturated at 10; otherwise it is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| borrowEn | input | 1 | Enables time borrowing |
| upSel | input | 2*FANIN | Current select of each upstream element, lane i at [2i+1:2i] |
| upErr | input | FANIN | Mismatch indication of each upstream element |
| localMismatch | input | 1 | Mismatch of the local element's two samples |
| selOut | output | 2 | Registered borrow select for the local element |
| errFlag | output | 1 | Registered error flag for the central controller |
| relayOut | output | 2 | Local relay request to downstream stages |

## Verification
The bench builds the block with a fan-in of five. A fan-in that is not a power of two makes the comparator tree pad its leaves with the lowest code, so the bench checks that the padding never wins the maximum. Five lanes also let a high request sit in the last, unpadded leaf while lower requests sit elsewhere. Directed cases cover saturation from code 10 and from the illegal code 11, the boundary between masked and flagged mismatches, and enable drops in the middle of an error burst. A long pseudo-random stretch then compares every cycle against a reference model.

// File: rtl/relay_sel_pkg.sv
package relay_sel_pkg;
  localparam int SEL_W = 2;
  typedef logic [SEL_W-1:0] sel_t;
  localparam sel_t SEL_TB   = 2'b00;
  localparam sel_t SEL_CEIL = 2'b10;

  typedef struct packed {
    logic relayOn;
    logic flagArm;
  } relay_ctrl_t;

  function automatic sel_t bumpSel(sel_t s);
    return (s >= SEL_CEIL) ? SEL_CEIL : sel_t'(s + 1'b1);
  endfunction

  function automatic sel_t maxSel(sel_t a, sel_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/relay_sel_ctrl.sv
module relay_sel_ctrl
  import relay_sel_pkg::*;
(
  input  logic        borrowEn,
  input  logic        localMismatch,
  input  logic        curInEd,
  output relay_ctrl_t strobes
);
  always_comb begin
    strobes.relayOn = borrowEn;
    strobes.flagArm = borrowEn & localMismatch & curInEd;
  end
endmodule

// File: rtl/relay_sel_dp.sv
module relay_sel_dp
  import relay_sel_pkg::*;
#(
  parameter int FANIN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  relay_ctrl_t        strobes,
  input  logic [2*FANIN-1:0] upSel,
  input  logic [FANIN-1:0]   upErr,
  input  logic               localMismatch,
  output sel_t               selOut,
  output logic               errFlag,
  output sel_t               relayOut,
  output logic               curInEd
);
  localparam int LEVELS = (FANIN > 1) ? $clog2(FANIN) : 0;
  localparam int PADN   = 1 << LEVELS;
  localparam int NODES  = 2 * PADN - 1;

  sel_t node [NODES];
  sel_t selQ;
  logic flagQ;
  sel_t nextSel;

  // leaves: per-lane request, padding lanes request the lowest code
  for (genvar j = 0; j < PADN; j++) begin : g_leaf
    if (j < FANIN) begin : g_live
      assign node[PADN-1+j] = upErr[j] ? bumpSel(upSel[2*j +: SEL_W]) : SEL_TB;
    end else begin : g_pad
      assign node[PADN-1+j] = SEL_TB;
    end
  end

  // balanced comparator tree, root at node 0
  for (genvar k = 0; k < PADN - 1; k++) begin : g_tree
    assign node[k] = maxSel(node[2*k+1], node[2*k+2]);
  end

  assign nextSel = strobes.relayOn ? node[0] : SEL_TB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= SEL_TB;
      flagQ <= 1'b0;
    end else begin
      selQ  <= nextSel;
      flagQ <= strobes.flagArm;
    end
  end

  assign selOut   = selQ;
  assign errFlag  = flagQ;
  assign curInEd  = (selQ != SEL_TB);
  assign relayOut = (strobes.relayOn && localMismatch) ? bumpSel(selQ) : SEL_TB;
endmodule

// File: rtl/borrow_relay_sel.sv
module borrow_relay_sel
  import relay_sel_pkg::*;
#(
  parameter int FANIN = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               borrowEn,
  input  logic [2*FANIN-1:0] upSel,
  input  logic [FANIN-1:0]   upErr,
  input  logic               localMismatch,
  output logic [1:0]         selOut,
  output logic               errFlag,
  output logic [1:0]         relayOut
);
  relay_ctrl_t strobes;
  logic        curInEd;

  relay_sel_ctrl u_ctrl (
    .borrowEn      (borrowEn),
    .localMismatch (localMismatch),
    .curInEd       (curInEd),
    .strobes       (strobes)
  );

  relay_sel_dp #(.FANIN(FANIN)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .upSel         (upSel),
    .upErr         (upErr),
    .localMismatch (localMismatch),
    .selOut        (selOut),
    .errFlag       (errFlag),
    .relayOut      (relayOut),
    .curInEd       (curInEd)
  );
endmodule

// File: rtl/relay_sel_chk.sv
module relay_sel_chk #(
  parameter int FANIN = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               borrowEn,
  input logic [FANIN-1:0]   upErr,
  input logic               localMismatch,
  input logic [1:0]         selOut,
  input logic               errFlag,
  input logic [1:0]         relayOut
);
  AST_NO_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(borrowEn) && ($past(upErr) == '0)) |-> (selOut == 2'b00)); // R6
  AST_ERR_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(borrowEn) && ($past(upErr) != '0)) |-> (selOut != 2'b00)); // R5
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rstN)
    selOut != 2'b11); // R5
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(borrowEn)) |-> (selOut == 2'b00 && !errFlag)); // R9
  AST_FLAG_IN_ED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(borrowEn) && $past(localMismatch) && ($past(selOut) != 2'b00)) |-> errFlag); // R7
  AST_TB_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (($past(selOut) == 2'b00) || !$past(localMismatch))) |-> !errFlag); // R8
  AST_RELAY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!borrowEn || !localMismatch) |-> (relayOut == 2'b00)); // R10
endmodule

bind borrow_relay_sel relay_sel_chk #(.FANIN(FANIN)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .borrowEn      (borrowEn),
  .upErr         (upErr),
  .localMismatch (localMismatch),
  .selOut        (selOut),
  .errFlag       (errFlag),
  .relayOut      (relayOut)
);

// File: tb/borrow_relay_sel_tb.sv
module borrow_relay_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FANIN = 5;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               borrowEn = 1'b0;
  logic [2*FANIN-1:0] upSel = '0;
  logic [FANIN-1:0]   upErr = '0;
  logic               localMismatch = 1'b0;
  logic [1:0]         selOut;
  logic               errFlag;
  logic [1:0]         relayOut;

  int checks = 0;
  int failures = 0;
  logic [1:0] expSel = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  borrow_relay_sel #(.FANIN(FANIN)) u_dut (
    .clk(clk), .rstN(rstN), .borrowEn(borrowEn), .upSel(upSel), .upErr(upErr),
    .localMismatch(localMismatch), .selOut(selOut), .errFlag(errFlag), .relayOut(relayOut)
  );

  function automatic logic [1:0] inc2(logic [1:0] s);
    return (s >= 2'b10) ? 2'b10 : s + 2'b01;
  endfunction

  function automatic logic [1:0] model(logic [2*FANIN-1:0] s, logic [FANIN-1:0] e, logic en);
    logic [1:0] m = 2'b00;
    if (!en) return 2'b00;
    for (int i = 0; i < FANIN; i++)
      if (e[i] && inc2(s[2*i +: 2]) > m) m = inc2(s[2*i +: 2]);
    return m;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle at negedge, check everything at the following negedge
  task automatic cycle(string req, logic [2*FANIN-1:0] s, logic [FANIN-1:0] e, logic mis, logic en);
    logic [1:0] nSel;
    logic nFlag;
    upSel = s; upErr = e; localMismatch = mis; borrowEn = en;
    #1;
    check({req, " relayOut"}, relayOut, (en && mis) ? inc2(expSel) : 0);
    check({req, " selOut before edge"}, selOut, expSel);
    nSel = model(s, e, en);
    nFlag = en && mis && (expSel != 2'b00);
    @(posedge clk);
    @(negedge clk);
    expSel = nSel;
    check({req, " selOut"}, selOut, nSel);
    check({req, " errFlag"}, errFlag, nFlag);
  endtask

  function automatic logic [2*FANIN-1:0] lane(int i, logic [1:0] v);
    logic [2*FANIN-1:0] r = '0;
    r[2*i +: 2] = v;
    return r;
  endfunction

  task automatic t_reset;
    rstN = 1'b0; borrowEn = 1'b1; upErr = '1; upSel = '1;
    repeat (2) @(negedge clk);
    check("R1 reset selOut", selOut, 0);
    check("R1 reset errFlag", errFlag, 0);
    upErr = '0; upSel = '0;
    rstN = 1'b1;
    @(negedge clk);
    expSel = 2'b00;
  endtask

  task automatic t_single;
    cycle("R2 lane2 00->01", lane(2, 2'b00), 5'b00100, 1'b0, 1'b1);
    cycle("R2 lane4 01->10", lane(4, 2'b01), 5'b10000, 1'b0, 1'b1);
    cycle("R6 converge", '0, '0, 1'b0, 1'b1);
  endtask

  task automatic t_quiet_lane;
    cycle("R3 quiet lane ignored", lane(0, 2'b10) | lane(1, 2'b00), 5'b00010, 1'b0, 1'b1);
    check("R3 quiet lane result", selOut, 1);
    cycle("R3 only quiet lanes", lane(3, 2'b10) | lane(4, 2'b01), 5'b00000, 1'b0, 1'b1);
  endtask

  task automatic t_max;
    cycle("R4 max three lanes", lane(0, 2'b00) | lane(2, 2'b01) | lane(4, 2'b00), 5'b10101, 1'b0, 1'b1);
    check("R4 max result", selOut, 2);
    cycle("R4 equal lanes", '0, 5'b11111, 1'b0, 1'b1);
    cycle("R4 last lane wins", lane(4, 2'b01), 5'b11111, 1'b0, 1'b1);
  endtask

  task automatic t_sat;
    cycle("R5 from 10", lane(1, 2'b10), 5'b00010, 1'b0, 1'b1);
    check("R5 saturated", selOut, 2);
    cycle("R5 from 11", lane(3, 2'b11), 5'b01000, 1'b0, 1'b1);
    cycle("R6 back to 00", '0, '0, 1'b0, 1'b1);
  endtask

  task automatic t_flag;
    cycle("R2 arm ED", lane(0, 2'b00), 5'b00001, 1'b0, 1'b1);
    cycle("R7 mismatch in 01", lane(0, 2'b00), 5'b00001, 1'b1, 1'b1);
    check("R7 flag raised", errFlag, 1);
    cycle("R10 relay from 01", lane(0, 2'b01), 5'b00001, 1'b1, 1'b1);
    cycle("R10 relay from 10", '0, '0, 1'b1, 1'b1);
    cycle("R8 mismatch in 00", '0, '0, 1'b1, 1'b1);
    check("R8 masked", errFlag, 0);
    cycle("R8 idle", '0, '0, 1'b0, 1'b1);
  endtask

  task automatic t_disable;
    cycle("R2 arm before disable", lane(2, 2'b01), 5'b00100, 1'b0, 1'b1);
    cycle("R9 disabled with errors", '1, '1, 1'b1, 1'b0);
    check("R9 select off", selOut, 0);
    cycle("R9 still disabled", '1, '1, 1'b1, 1'b0);
    check("R9 flag off", errFlag, 0);
    cycle("R9 re-enable", '0, '0, 1'b0, 1'b1);
  endtask

  task automatic t_random;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      cycle("R4 random", lfsr[2*FANIN-1:0], lfsr[2*FANIN +: FANIN] & lfsr[20 +: FANIN],
            lfsr[27], lfsr[29] | lfsr[30]);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_quiet_lane();
    t_max();
    t_sat();
    t_flag();
    t_disable();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule